// File: doc/BRIEF.md
# Aliased Control Register Bank with Soft Reset

This block holds the 32-bit control and status words of a peripheral such as a PHY, behind a simple word-aligned register bus. Six of the writable words each own a group of four consecutive word addresses. The first address of a group is a plain read/write location. The other three addresses modify the same word: one sets bits, one clears bits and one flips bits. Software can therefore change single fields without a read-modify-write sequence.

One more word is writable only at its own address. Two words are read-only constants. Every other word in the 4 KB window reads as zero and ignores writes.

Bit 31 of the control word is a soft-reset request. When it fires, the power, transmit, receive and control words return to their defaults. The debug and status words keep their contents. Whether a write to the control word fires the soft reset depends on which of the four addresses it used.

A hardware reset returns every word to its power-on value. An access with a misaligned address, or with any byte-enable bit low, is flagged on an error output. Such an access changes nothing.

Top module: `alias_reg_bank`

## Requirements
- R1: After hardware reset the words read as follows: power 0x001E1C00, transmit 0x10060607, receive 0x00000000, control 0xC0200000, status 0x00000000, debug 0x7F180000, debug snapshot 0x00000000, extended debug 0x00001000, revision 0x04020000.
- R2: The grouped words sit at these word indices: power 0, transmit 4, receive 8, control 12, debug 20 and extended debug 28. A write to the first index of a group replaces the whole word. The status word, at word index 16, is replaced by a write to that index.
- R3: A write to group index +1 ORs the write data into the group's word.
- R4: A write to group index +2 clears the bits of the word that are set in the write data.
- R5: A write to group index +3 XORs the write data into the word.
- R6: A read of any of the four indices of a group returns the group's current word.
- R7: A soft reset reloads power, transmit, receive and control with their R1 values. Status, debug and extended debug keep their contents.
- R8: A write to control at its plain index (+0) or its set index (+1) with data bit 31 set performs the write, then the soft reset, so control ends at 0xC0200000.
- R9: A flip write (+3) to control fires the soft reset only if data bit 31 is set and control bit 31 is 1 after the flip. A clear write (+2) never fires it.
- R10: Writes to the debug snapshot (index 24), the revision (index 32), indices 17 to 19 and any other unmapped word leave every word unchanged.
- R11: Reads of indices 17 to 19, 25 to 27, and 33 upward within the window return 0.
- R12: An access whose byte address has nonzero low two bits, or whose byte enables are not all ones, raises the error output in that cycle. It also returns read data 0 and changes no word.
- R13: Read data follows the address combinationally. A write takes effect on the rising clock edge that ends its cycle, so the same cycle still reads the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_be | input | 4 | Byte enables; only all ones is valid |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| bus_err | output | 1 | Invalid access flag, combinational |

## Verification
The assertions assume that hardware reset is applied from time zero. They also assume that bus inputs change only away from the rising edge, and that bus_wdata is meaningful whenever a valid write is strobed. The bench drives every input at the falling edge and holds reset low for the first cycles. Its random phase keeps addresses inside the window and still mixes in misaligned addresses and partial byte enables, so the error path is exercised.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int WORD_W      = 32;
  localparam int BE_W        = WORD_W / 8;
  localparam int NUM_GRP     = 6;
  localparam int CTRL_GRP    = 3;   // group holding the soft-reset bit
  localparam int SRST_BIT    = 31;
  localparam int IDX_STATUS  = 16;
  localparam int IDX_SNAP    = 24;
  localparam int IDX_REV     = 32;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t STATUS_RST = 32'h0000_0000;
  localparam word_t SNAP_VAL   = 32'h0000_0000;
  localparam word_t REV_VAL    = 32'h0402_0000;

  // Low two bits of the word index select how a grouped word is modified.
  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } alias_op_e;

  // First word index of each aliased group.
  function automatic int grp_base(input int g);
    case (g)
      0:       return 0;    // power
      1:       return 4;    // transmit
      2:       return 8;    // receive
      3:       return 12;   // control
      4:       return 20;   // debug
      default: return 28;   // extended debug
    endcase
  endfunction

  function automatic word_t grp_default(input int g);
    case (g)
      0:       return 32'h001E_1C00;
      1:       return 32'h1006_0607;
      2:       return 32'h0000_0000;
      3:       return 32'hC020_0000;
      4:       return 32'h7F18_0000;
      default: return 32'h0000_1000;
    endcase
  endfunction

  // Groups reloaded by a soft reset.
  function automatic bit grp_soft(input int g);
    return g <= CTRL_GRP;
  endfunction

  // Next value of a grouped word for a given alias operation.
  function automatic word_t alias_apply(input alias_op_e op, input word_t cur,
                                        input word_t d);
    case (op)
      OP_WR:   return d;
      OP_SET:  return cur | d;
      OP_CLR:  return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction
endpackage

// File: rtl/arb_decode.sv
module arb_decode
  import arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                   sel,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BE_W-1:0]        be,
  output logic [NUM_GRP-1:0]     grp_hit,
  output alias_op_e              op,
  output logic                   stat_hit,
  output logic                   snap_hit,
  output logic                   rev_hit,
  output logic                   acc_err,
  output logic                   wr_ok
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  assign acc_err = sel && ((addr[1:0] != 2'b00) || (be != {BE_W{1'b1}}));
  assign wr_ok   = sel && we && !acc_err;
  assign op      = alias_op_e'(idx[1:0]);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_hit
    localparam logic [IW-3:0] GSEL = (IW-2)'(grp_base(g) / 4);
    assign grp_hit[g] = (idx[IW-1:2] == GSEL);
  end

  assign stat_hit = (idx == IW'(IDX_STATUS));
  assign snap_hit = (idx == IW'(IDX_SNAP));
  assign rev_hit  = (idx == IW'(IDX_REV));
endmodule

// File: rtl/arb_slot.sv
module arb_slot
  import arb_pkg::*;
#(
  parameter word_t RST_VAL = '0,
  parameter bit    SOFT_EN = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  alias_op_e op,
  input  word_t     wdata,
  input  logic      srst,
  output word_t     q,
  output word_t     q_nxt
);
  assign q_nxt = alias_apply(op, q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= RST_VAL;
    else if (SOFT_EN && srst) q <= RST_VAL;
    else if (wr_hit)          q <= q_nxt;
  end
endmodule

// File: rtl/arb_rdmux.sv
module arb_rdmux
  import arb_pkg::*;
(
  input  logic [NUM_GRP-1:0]             grp_hit,
  input  logic [NUM_GRP-1:0][WORD_W-1:0] grp_q,
  input  word_t                          stat_q,
  input  logic                           stat_hit,
  input  logic                           snap_hit,
  input  logic                           rev_hit,
  input  logic                           acc_err,
  output word_t                          rdata
);
  always_comb begin
    rdata = '0;
    if (!acc_err) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (grp_hit[g]) rdata = grp_q[g];
      end
      if (stat_hit) rdata = stat_q;
      if (snap_hit) rdata = SNAP_VAL;
      if (rev_hit)  rdata = REV_VAL;
    end
  end
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);
  logic [NUM_GRP-1:0]             grp_hit;
  alias_op_e                      op;
  logic                           stat_hit, snap_hit, rev_hit;
  logic                           acc_err, wr_ok;
  logic [NUM_GRP-1:0][WORD_W-1:0] grp_q;
  logic [NUM_GRP-1:0][WORD_W-1:0] grp_nxt;
  logic                           srst_fire;
  word_t                          stat_q;

  arb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .be       (bus_be),
    .grp_hit  (grp_hit),
    .op       (op),
    .stat_hit (stat_hit),
    .snap_hit (snap_hit),
    .rev_hit  (rev_hit),
    .acc_err  (acc_err),
    .wr_ok    (wr_ok)
  );

  // The soft reset fires when the written bit 31 is set and survives the
  // alias operation. This covers the plain, set and flip paths and excludes clear.
  assign srst_fire = wr_ok && grp_hit[CTRL_GRP] && bus_wdata[SRST_BIT]
                     && grp_nxt[CTRL_GRP][SRST_BIT];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
    arb_slot #(
      .RST_VAL (grp_default(g)),
      .SOFT_EN (grp_soft(g))
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_ok && grp_hit[g]),
      .op     (op),
      .wdata  (bus_wdata),
      .srst   (srst_fire),
      .q      (grp_q[g]),
      .q_nxt  (grp_nxt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stat_q <= STATUS_RST;
    else if (wr_ok && stat_hit) stat_q <= bus_wdata;
  end

  arb_rdmux u_rd (
    .grp_hit  (grp_hit),
    .grp_q    (grp_q),
    .stat_q   (stat_q),
    .stat_hit (stat_hit),
    .snap_hit (snap_hit),
    .rev_hit  (rev_hit),
    .acc_err  (acc_err),
    .rdata    (bus_rdata)
  );

  assign bus_err = acc_err;
endmodule

// File: rtl/arb_chk.sv
module arb_chk
  import arb_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           acc_err,
  input logic                           wr_ok,
  input logic [NUM_GRP-1:0]             grp_hit,
  input alias_op_e                      op,
  input logic                           srst_fire,
  input logic [NUM_GRP-1:0][WORD_W-1:0] grp_q,
  input word_t                          stat_q,
  input logic [31:0]                    bus_wdata
);
  AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> ($stable(grp_q) && $stable(stat_q)));  // R12

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(grp_q) && $stable(stat_q)));  // R10

  AST_SET_ORS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp_hit[1] && op == OP_SET)
      |=> (grp_q[1] == ($past(grp_q[1]) | $past(bus_wdata))));  // R3

  AST_CLR_KEEPS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp_hit[1] && op == OP_CLR)
      |=> ((grp_q[1] & $past(bus_wdata)) == '0));  // R4

  AST_SRST_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> (grp_q[0] == grp_default(0) && grp_q[1] == grp_default(1) &&
                   grp_q[2] == grp_default(2) && grp_q[3] == grp_default(3)));  // R7

  AST_SRST_SPARES_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> ($stable(grp_q[4]) && $stable(grp_q[5]) && $stable(stat_q)));  // R7

  AST_PLAIN_SET_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp_hit[CTRL_GRP] && (op == OP_WR || op == OP_SET) && bus_wdata[SRST_BIT])
      |-> srst_fire);  // R8

  AST_CLR_NEVER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp_hit[CTRL_GRP] && op == OP_CLR) |-> !srst_fire);  // R9
endmodule

bind alias_reg_bank arb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_err   (acc_err),
  .wr_ok     (wr_ok),
  .grp_hit   (grp_hit),
  .op        (op),
  .srst_fire (srst_fire),
  .grp_q     (grp_q),
  .stat_q    (stat_q),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_alias_reg_bank.sv
`timescale 1ns/100ps
module tb_alias_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         err;

  always #2.5 clk = ~clk;

  alias_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model slots: 0 power, 1 tx, 2 rx, 3 control, 4 status, 5 debug,
  // 6 debug snapshot, 7 extended debug, 8 revision
  logic [31:0] m [0:8];

  task automatic model_soft();
    m[0] = 32'h001E_1C00; m[1] = 32'h1006_0607;
    m[2] = 32'h0000_0000; m[3] = 32'hC020_0000;
  endtask

  task automatic model_hard();
    model_soft();
    m[4] = 0; m[5] = 32'h7F18_0000; m[6] = 0; m[7] = 32'h0000_1000; m[8] = 32'h0402_0000;
  endtask

  function automatic int slot_of_group(input int grp);
    if (grp == 0 || grp == 1 || grp == 2 || grp == 3 || grp == 5 || grp == 7) return grp;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(input int w);
    int s;
    s = slot_of_group(w / 4);
    if (s >= 0) return m[s];
    if (w == 16) return m[4];
    if (w == 24) return m[6];
    if (w == 32) return m[8];
    return 32'h0;
  endfunction

  task automatic model_write(input int w, input logic [31:0] d);
    int s;
    int o;
    s = slot_of_group(w / 4);
    o = w % 4;
    if (s >= 0) begin
      case (o)
        0: m[s] = d;
        1: m[s] = m[s] | d;
        2: m[s] = m[s] & ~d;
        default: m[s] = m[s] ^ d;
      endcase
      if (s == 3) begin
        if ((o == 0 || o == 1) && d[31]) model_soft();
        else if (o == 3 && d[31] && m[3][31]) model_soft();
      end
    end else if (w == 16) begin
      m[4] = d;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, compare outputs 1 ns later,
  // update the model after the rising edge that commits the write.
  task automatic access(input logic w_en, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] b, input string tag);
    logic bad;
    @(negedge clk);
    sel = 1'b1; we = w_en; addr = a; wdata = d; be = b;
    #1;
    bad = (a[1:0] != 2'b00) || (b != 4'hF);
    check(tag, "rdata", rdata, bad ? 32'h0 : model_read(int'(a >> 2)));
    check(tag, "err", {31'b0, err}, {31'b0, bad});
    @(posedge clk);
    if (w_en && !bad) model_write(int'(a >> 2), d);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    access(1'b1, a, d, 4'hF, tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    access(1'b0, a, 32'h0, 4'hF, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_hard();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: defaults at every base word
    rd(12'h000, "R1"); rd(12'h010, "R1"); rd(12'h020, "R1"); rd(12'h030, "R1");
    rd(12'h040, "R1"); rd(12'h050, "R1"); rd(12'h060, "R1"); rd(12'h070, "R1");
    rd(12'h080, "R1");
    // R6: aliases read the base word
    rd(12'h014, "R6"); rd(12'h038, "R6"); rd(12'h07C, "R6");

    // R2 and R13: the write cycle still shows the old value
    wr(12'h000, 32'h1234_5678, "R13"); rd(12'h000, "R2");
    wr(12'h040, 32'h0000_0055, "R2"); rd(12'h040, "R2");
    wr(12'h070, 32'h0000_0077, "R2"); rd(12'h074, "R6");
    // R3, R4, R5 on transmit and debug
    wr(12'h014, 32'h0F00_00F0, "R3"); rd(12'h010, "R3");
    wr(12'h018, 32'h1000_0007, "R4"); rd(12'h010, "R4");
    wr(12'h01C, 32'hFFFF_0000, "R5"); rd(12'h010, "R5");
    wr(12'h054, 32'h0000_AAAA, "R3"); wr(12'h05C, 32'h7F00_0001, "R5"); rd(12'h050, "R5");
    wr(12'h058, 32'h0018_0000, "R4"); rd(12'h050, "R4");

    // R10, R11: ignored writes and unmapped reads
    wr(12'h044, 32'hFFFF_FFFF, "R10"); rd(12'h044, "R11"); rd(12'h040, "R10");
    wr(12'h060, 32'hDEAD_BEEF, "R10"); rd(12'h060, "R10");
    wr(12'h080, 32'hDEAD_BEEF, "R10"); rd(12'h080, "R10");
    wr(12'h084, 32'h1111_1111, "R10"); rd(12'h084, "R11"); rd(12'h064, "R11");
    rd(12'hFFC, "R11");

    // R12: misaligned and partial byte enables
    access(1'b1, 12'h001, 32'hFFFF_FFFF, 4'hF, "R12"); rd(12'h000, "R12");
    access(1'b1, 12'h010, 32'h0, 4'b0111, "R12"); rd(12'h010, "R12");
    access(1'b0, 12'h022, 32'h0, 4'hF, "R12");

    // R7, R8: plain write of bit 31 to control
    wr(12'h020, 32'h0000_00AB, "R7");
    wr(12'h030, 32'h8000_0001, "R8");
    rd(12'h030, "R8"); rd(12'h000, "R7"); rd(12'h010, "R7"); rd(12'h020, "R7");
    rd(12'h050, "R7"); rd(12'h040, "R7"); rd(12'h070, "R7");
    // R8: set alias
    wr(12'h000, 32'h0000_0001, "R8"); wr(12'h034, 32'h8000_0000, "R8"); rd(12'h000, "R8");
    // R9: flip clears bit 31 -> no reset, flip again -> reset
    wr(12'h000, 32'h0000_0002, "R9"); wr(12'h03C, 32'h8000_0000, "R9");
    rd(12'h030, "R9"); rd(12'h000, "R9");
    wr(12'h03C, 32'h8000_0000, "R9"); rd(12'h000, "R9"); rd(12'h030, "R9");
    // R9: clear path never resets
    wr(12'h000, 32'h0000_0003, "R9"); wr(12'h038, 32'h8000_0000, "R9");
    rd(12'h000, "R9"); rd(12'h030, "R9");
    // R2: plain control write without bit 31
    wr(12'h030, 32'h0000_0F0F, "R2"); rd(12'h000, "R2"); rd(12'h030, "R2");

    // Mixed random traffic against the model (R6 and the alias rules)
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [3:0]  b;
      a = 12'($urandom_range(0, 36) * 4);
      if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
      b = ($urandom_range(0, 9) == 0) ? 4'b1011 : 4'hF;
      access(1'($urandom_range(0, 1)), a, $urandom(), b, "R6");
    end

    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule